// File: doc/BRIEF.md
# Arithmetic Unit with Four-Flag Register

This block is the datapath arithmetic stage of a small 32-bit processor core. It takes two operands and a 6-bit operation code. A single combinational path produces the result, covering logical shifts, bitwise logic, addition, subtraction and multiplication. Operand selection between register and immediate sources happens upstream. Writeback of the result happens downstream.

Alongside the result, the block keeps a four-bit condition register: carry, negative, zero and positive. The register loads on a clock edge only when the update strobe is high. The sequencer raises that strobe when an instruction that passed its condition check actually executes. Every load rewrites all four bits, so a flag that the operation does not produce is cleared and never carried over.

Top module: `arith_flag_unit`

## Requirements
- R1: A synchronous active-high `rst` clears `flags` to 4'b0000 on the next rising edge, even when `upd_en` is high.
- R2: Opcodes 0 and 1 shift `op_a` left and opcodes 2 and 3 shift it right, filling with zeros, by the unsigned amount in `op_b`. An amount of 32 or more gives a zero result.
- R3: Opcodes 4 and 5 give `op_a & op_b`, opcodes 6 and 7 give `op_a | op_b`, and opcodes 8 and 9 give `op_a ^ op_b`.
- R4: Opcode 10 gives `~op_a`, and the value of `op_b` has no effect on the result or on the flags.
- R5: Opcodes 11 and 12 give `op_a + op_b` modulo 2^32, with C equal to the carry out of bit 31.
- R6: Opcodes 13 and 14 give `op_a - op_b` in two's complement, with C set when `op_a < op_b` as unsigned numbers (a borrow).
- R7: Opcodes 15 and 16 give the low 32 bits of the unsigned 64-bit product, with C set when the upper 32 bits of that product are nonzero.
- R8: The bits of `flags` are [3]=C, [2]=N, [1]=Z and [0]=P. N, Z and P come from the 32-bit result read as signed (below zero, equal to zero, above zero), so exactly one of them is set after any load.
- R9: Shift, bitwise and NOT operations load C as 0. Opcodes 17 to 63 give a zero result and load flags 4'b0010.
- R10: `flags` changes only on a rising edge with `upd_en` high. With `upd_en` low it holds its value whatever the operands and opcode do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the flag register |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand, also the shift amount |
| opcode | input | 6 | Operation code |
| upd_en | input | 1 | Load the flag register with this operation's flags |
| result | output | 32 | Combinational result |
| flags | output | 4 | Registered C, N, Z, P |

## Verification
Shifts are tried at amounts 0, 31, 32 and far beyond 32, which separates the in-range barrel path from the overflow clamp. Addition, subtraction and multiplication are each run once with a clean result and once where the carry, borrow or upper-half bit must be raised. Some of these corner results land on zero or on a negative value, so the Z and N derivation is checked against the C bit. A carry-producing add followed by a bitwise operation shows that C is cleared rather than held. Operand changes with the strobe low, and a reset with the strobe high, show which events may touch the register.

// File: rtl/afu_pkg.sv
`timescale 1ns/1ps
package afu_pkg;

  localparam int OPC_W = 6;

  typedef enum logic [3:0] {
    CL_SHL, CL_SHR, CL_AND, CL_OR, CL_XOR, CL_NOT,
    CL_ADD, CL_SUB, CL_MUL, CL_NONE
  } op_class_e;

  typedef struct packed {
    logic c;
    logic n;
    logic z;
    logic p;
  } flags_t;

  function automatic op_class_e decode_op(input logic [OPC_W-1:0] opc);
    op_class_e cls;
    case (opc)
      6'd0, 6'd1:   cls = CL_SHL;
      6'd2, 6'd3:   cls = CL_SHR;
      6'd4, 6'd5:   cls = CL_AND;
      6'd6, 6'd7:   cls = CL_OR;
      6'd8, 6'd9:   cls = CL_XOR;
      6'd10:        cls = CL_NOT;
      6'd11, 6'd12: cls = CL_ADD;
      6'd13, 6'd14: cls = CL_SUB;
      6'd15, 6'd16: cls = CL_MUL;
      default:      cls = CL_NONE;
    endcase
    return cls;
  endfunction

endpackage

// File: rtl/afu_shift.sv
`timescale 1ns/1ps
module afu_shift #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] val,
  input  logic [DATA_W-1:0] amt,
  input  logic              go_right,
  output logic [DATA_W-1:0] shifted
);
  localparam int SH_W = $clog2(DATA_W);

  logic [DATA_W-1:0] stage [SH_W+1];
  logic              too_far;

  assign stage[0] = val;

  genvar gi;
  generate
    for (gi = 0; gi < SH_W; gi++) begin : g_stage
      localparam int DIST = 1 << gi;
      assign stage[gi+1] = !amt[gi] ? stage[gi] :
                           (go_right ? (stage[gi] >> DIST) : (stage[gi] << DIST));
    end
  endgenerate

  assign too_far = |amt[DATA_W-1:SH_W];
  assign shifted = too_far ? '0 : stage[SH_W];
endmodule

// File: rtl/afu_bitwise.sv
`timescale 1ns/1ps
module afu_bitwise
  import afu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  op_class_e         cls,
  output logic [DATA_W-1:0] y
);
  always_comb begin
    case (cls)
      CL_AND:  y = a & b;
      CL_OR:   y = a | b;
      CL_XOR:  y = a ^ b;
      CL_NOT:  y = ~a;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/afu_arith.sv
`timescale 1ns/1ps
module afu_arith
  import afu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  op_class_e         cls,
  output logic [DATA_W-1:0] y,
  output logic              carry
);
  localparam int PROD_W = 2 * DATA_W;

  logic [DATA_W:0]   sum_ext;
  logic [DATA_W:0]   dif_ext;
  logic [PROD_W-1:0] prod;

  assign sum_ext = {1'b0, a} + {1'b0, b};
  assign dif_ext = {1'b0, a} - {1'b0, b};
  assign prod    = {{DATA_W{1'b0}}, a} * {{DATA_W{1'b0}}, b};

  always_comb begin
    case (cls)
      CL_ADD: begin
        y     = sum_ext[DATA_W-1:0];
        carry = sum_ext[DATA_W];
      end
      CL_SUB: begin
        y     = dif_ext[DATA_W-1:0];
        carry = dif_ext[DATA_W];
      end
      CL_MUL: begin
        y     = prod[DATA_W-1:0];
        carry = |prod[PROD_W-1:DATA_W];
      end
      default: begin
        y     = '0;
        carry = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/afu_flag_reg.sv
`timescale 1ns/1ps
module afu_flag_reg
  import afu_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   load,
  input  flags_t d,
  output flags_t q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/arith_flag_unit.sv
`timescale 1ns/1ps
module arith_flag_unit
  import afu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [OPC_W-1:0]  opcode,
  input  logic              upd_en,
  output logic [DATA_W-1:0] result,
  output logic [3:0]        flags
);
  op_class_e         cls;
  logic [DATA_W-1:0] sh_y, bw_y, ar_y;
  logic              ar_c;
  logic              is_shift, is_arith;
  flags_t            nxt, cur;

  assign cls      = decode_op(opcode);
  assign is_shift = (cls == CL_SHL) || (cls == CL_SHR);
  assign is_arith = (cls == CL_ADD) || (cls == CL_SUB) || (cls == CL_MUL);

  afu_shift #(.DATA_W(DATA_W)) u_shift (
    .val      (op_a),
    .amt      (op_b),
    .go_right (cls == CL_SHR),
    .shifted  (sh_y)
  );

  afu_bitwise #(.DATA_W(DATA_W)) u_bitwise (
    .a   (op_a),
    .b   (op_b),
    .cls (cls),
    .y   (bw_y)
  );

  afu_arith #(.DATA_W(DATA_W)) u_arith (
    .a     (op_a),
    .b     (op_b),
    .cls   (cls),
    .y     (ar_y),
    .carry (ar_c)
  );

  always_comb begin
    if (is_shift)      result = sh_y;
    else if (is_arith) result = ar_y;
    else               result = bw_y;
  end

  always_comb begin
    nxt.c = is_arith & ar_c;
    nxt.n = result[DATA_W-1];
    nxt.z = (result == '0);
    nxt.p = !result[DATA_W-1] && (result != '0);
  end

  afu_flag_reg u_flags (
    .clk  (clk),
    .rst  (rst),
    .load (upd_en),
    .d    (nxt),
    .q    (cur)
  );

  assign flags = cur;
endmodule

// File: rtl/afu_checker.sv
`timescale 1ns/1ps
module afu_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b,
  input logic [5:0]        opcode,
  input logic              upd_en,
  input logic [DATA_W-1:0] result,
  input logic [3:0]        flags
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (flags == 4'b0000));

  assert_shift_clamp_R2: assert property (@(posedge clk) disable iff (rst)
    ((opcode <= 6'd3) && (op_b >= DATA_W)) |-> (result == '0));

  assert_not_ignores_b_R4: assert property (@(posedge clk) disable iff (rst)
    (opcode == 6'd10) |-> (result == ~op_a));

  assert_one_sign_flag_R8: assert property (@(posedge clk) disable iff (rst)
    upd_en |=> ($countones(flags[2:0]) == 1));

  assert_zero_tracks_result_R8: assert property (@(posedge clk) disable iff (rst)
    upd_en |=> (flags[1] == ($past(result) == '0)));

  assert_carry_cleared_logic_R9: assert property (@(posedge clk) disable iff (rst)
    (upd_en && (opcode <= 6'd10)) |=> !flags[3]);

  assert_unused_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (opcode > 6'd16) |-> (result == '0));

  assert_hold_without_strobe_R10: assert property (@(posedge clk) disable iff (rst)
    !upd_en |=> $stable(flags));
endmodule

bind arith_flag_unit afu_checker #(.DATA_W(DATA_W)) u_afu_checker (
  .clk    (clk),
  .rst    (rst),
  .op_a   (op_a),
  .op_b   (op_b),
  .opcode (opcode),
  .upd_en (upd_en),
  .result (result),
  .flags  (flags)
);

// File: tb/arith_flag_unit_bench.sv
`timescale 1ns/1ps
module arith_flag_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [5:0]  opcode = '0;
  logic        upd_en = 1'b0;
  logic [31:0] result;
  logic [3:0]  flags;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  arith_flag_unit u_arith_flag_unit (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b),
    .opcode(opcode), .upd_en(upd_en), .result(result), .flags(flags)
  );

  function automatic logic [32:0] model(input logic [5:0] op, input logic [31:0] a, input logic [31:0] b);
    logic [63:0] p;
    logic [32:0] r;
    case (op)
      6'd0, 6'd1:   r = (b >= 32) ? 33'd0 : {1'b0, a << b[4:0]};
      6'd2, 6'd3:   r = (b >= 32) ? 33'd0 : {1'b0, a >> b[4:0]};
      6'd4, 6'd5:   r = {1'b0, a & b};
      6'd6, 6'd7:   r = {1'b0, a | b};
      6'd8, 6'd9:   r = {1'b0, a ^ b};
      6'd10:        r = {1'b0, ~a};
      6'd11, 6'd12: r = {1'b0, a} + {1'b0, b};
      6'd13, 6'd14: r = {(a < b), a - b};
      6'd15, 6'd16: begin p = {32'd0, a} * {32'd0, b}; r = {|p[63:32], p[31:0]}; end
      default:      r = 33'd0;
    endcase
    return r;
  endfunction

  function automatic logic [3:0] flags_of(input logic [32:0] r);
    return {r[32], r[31], r[31:0] == 32'd0, !r[31] && (r[31:0] != 32'd0)};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_lit(input string req, input logic [5:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic [31:0] exp_res, input logic [3:0] exp_fl);
    @(negedge clk);
    opcode = op; op_a = a; op_b = b; upd_en = 1'b1;
    #2;
    chk(req, "result", result, exp_res);
    @(posedge clk); #2;
    chk(req, "flags", {28'd0, flags}, {28'd0, exp_fl});
  endtask

  task automatic run_model(input string req, input logic [5:0] op, input logic [31:0] a, input logic [31:0] b);
    logic [32:0] e;
    e = model(op, a, b);
    run_lit(req, op, a, b, e[31:0], flags_of(e));
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    chk("R1", "flags after reset", {28'd0, flags}, 32'd0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_shift;
    run_model("R2", 6'd0, 32'h8000_0001, 32'd0);
    run_lit  ("R2", 6'd1, 32'h0000_0003, 32'd31, 32'h8000_0000, 4'b0100);
    run_lit  ("R2", 6'd0, 32'hFFFF_FFFF, 32'd32, 32'h0, 4'b0010);
    run_lit  ("R2", 6'd2, 32'h8000_0000, 32'd31, 32'h1, 4'b0001);
    run_lit  ("R2", 6'd3, 32'hFFFF_FFFF, 32'h0001_0004, 32'h0, 4'b0010);
    run_model("R2", 6'd3, 32'hF0F0_1234, 32'd4);
  endtask

  task automatic t_logic;
    run_model("R3", 6'd4, 32'hF0F0_FF00, 32'h0FF0_F0F0);
    run_model("R3", 6'd7, 32'h8000_0000, 32'h0000_00AA);
    run_lit  ("R3", 6'd8, 32'h1234_5678, 32'h1234_5678, 32'h0, 4'b0010);
  endtask

  task automatic t_not;
    run_lit("R4", 6'd10, 32'hFFFF_FFFE, 32'h0, 32'h1, 4'b0001);
    run_lit("R4", 6'd10, 32'hFFFF_FFFE, 32'hDEAD_BEEF, 32'h1, 4'b0001);
  endtask

  task automatic t_add;
    run_lit  ("R5", 6'd11, 32'hFFFF_FFFF, 32'd1, 32'h0, 4'b1010);
    run_lit  ("R5", 6'd12, 32'h7FFF_FFFF, 32'd1, 32'h8000_0000, 4'b0100);
    run_model("R5", 6'd11, 32'd100, 32'd23);
  endtask

  task automatic t_sub;
    run_lit("R6", 6'd13, 32'd3, 32'd5, 32'hFFFF_FFFE, 4'b1100);
    run_lit("R6", 6'd14, 32'd5, 32'd3, 32'd2, 4'b0001);
    run_lit("R6", 6'd13, 32'd9, 32'd9, 32'd0, 4'b0010);
  endtask

  task automatic t_mul;
    run_lit  ("R7", 6'd15, 32'h0001_0000, 32'h0001_0000, 32'h0, 4'b1010);
    run_lit  ("R7", 6'd16, 32'd7, 32'd6, 32'd42, 4'b0001);
    run_model("R7", 6'd15, 32'hFFFF_FFFF, 32'd3);
  endtask

  task automatic t_sign_flags;
    run_lit("R8", 6'd6, 32'h8000_0000, 32'h0, 32'h8000_0000, 4'b0100);
    run_lit("R8", 6'd6, 32'h0, 32'h0, 32'h0, 4'b0010);
    run_lit("R8", 6'd6, 32'h0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 4'b0001);
  endtask

  task automatic t_clear_carry;
    run_lit("R9", 6'd11, 32'hFFFF_FFFF, 32'd2, 32'd1, 4'b1001);
    run_lit("R9", 6'd5,  32'hFFFF_FFFF, 32'd2, 32'd2, 4'b0001);
    run_lit("R9", 6'd11, 32'hFFFF_FFFF, 32'd2, 32'd1, 4'b1001);
    run_lit("R9", 6'd0,  32'h1, 32'd1, 32'd2, 4'b0001);
    run_lit("R9", 6'd40, 32'h1234, 32'h5678, 32'h0, 4'b0010);
    run_lit("R9", 6'd63, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 4'b0010);
  endtask

  task automatic t_hold;
    run_lit("R10", 6'd13, 32'd0, 32'd1, 32'hFFFF_FFFF, 4'b1100);
    @(negedge clk);
    upd_en = 1'b0; opcode = 6'd11; op_a = 32'd0; op_b = 32'd0;
    repeat (2) @(posedge clk);
    #2;
    chk("R10", "flags held", {28'd0, flags}, 32'hC);
    @(negedge clk);
    opcode = 6'd16; op_a = 32'd5; op_b = 32'd5;
    @(posedge clk); #2;
    chk("R10", "flags held after op change", {28'd0, flags}, 32'hC);
  endtask

  task automatic t_reset_priority;
    @(negedge clk);
    rst = 1'b1; upd_en = 1'b1; opcode = 6'd6; op_a = 32'd1; op_b = 32'd0;
    @(posedge clk); #2;
    chk("R1", "reset beats strobe", {28'd0, flags}, 32'd0);
    @(negedge clk); rst = 1'b0; upd_en = 1'b0;
  endtask

  bit done = 1'b0;

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_shift();
    t_logic();
    t_not();
    t_add();
    t_sub();
    t_mul();
    t_sign_flags();
    t_clear_carry();
    t_hold();
    t_reset_priority();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule